// File: doc/BRIEF.md
# OTG Session Timeout Timer

This block is a one-shot countdown timer held in a single 32-bit register. Software writes one word that carries both a start flag and a tick count. While armed, the timer counts the device-clock ticks it receives on a tick-enable input. When the count runs out, the timer sends a one-cycle timeout event to the interrupt aggregator, which latches it as its timeout source bit 16.

The register reads back whatever was last written. When the timer expires, the register is cleared to zero. It does not keep a terminal count. Software can tell from a zero read-back that the timeout has already fired. A write with the start flag clear disarms the timer. A write with the flag set re-arms it from the new count. The tick input stands for the 60 MHz device clock, so a count of N spans N/60e6 seconds.

Top module: `otg_timeout_timer`

## Requirements
- R1: After reset, `rd_data` reads 0 and `timeout` is low.
- R2: After any write, `rd_data` returns all 32 written bits unchanged, including bits 30:27, until the next write or an expiry.
- R3: A write with bit 31 set arms the timer with the count in bits 26:0. For a count N of at least 1, `timeout` rises in the cycle after the clock edge that samples the Nth `tick`, and not before.
- R4: An arming write with a count of 0 expires on the first `tick` after the write.
- R5: Bits 30:27 of an arming write have no effect on the number of ticks to expiry.
- R6: An arming write while a countdown is running restarts the countdown from the new count. Ticks before that write do not count.
- R7: A write with bit 31 clear cancels any countdown, and no `timeout` pulse follows from it.
- R8: On expiry, `rd_data` reads 0 in the same cycle that `timeout` is high, and `timeout` is high for exactly one cycle.
- R9: After expiry, further ticks cause no `timeout` until the next arming write.
- R10: Only cycles with `tick` high advance the countdown. A `tick` that arrives in the same cycle as a write is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value: bit 31 = start flag, bits 26:0 = tick count |
| tick | input | 1 | Device-clock tick enable, one count per high cycle |
| rd_data | output | 32 | Current register value |
| timeout | output | 1 | One-cycle expiry event to the interrupt aggregator |

## Verification
A wrong count in the down-counter shows at the ports as a `timeout` that comes one or more ticks early or late. The checks therefore watch every tick up to and just past the programmed count. A stale run flag shows as a pulse after a cancel, or as a second pulse after expiry. Both appear within one tick of the stimulus. A value register that is not cleared on expiry shows as a nonzero `rd_data` in the pulse cycle, so that mismatch is visible in the same cycle.

// File: rtl/otgt_pkg.sv
package otgt_pkg;

    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned CNT_W_DEF  = 27;

    // Command seen by the countdown each cycle, decoded from the write port.
    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_LOAD   = 2'd1,
        CMD_CANCEL = 2'd2
    } otgt_cmd_e;

endpackage

// File: rtl/otgt_wr_decode.sv
module otgt_wr_decode
    import otgt_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF
) (
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output otgt_cmd_e         cmd_o,
    output logic [CNT_W-1:0]  load_cnt_o
);

    localparam int unsigned EN_BIT = DATA_W - 1;

    always_comb begin
        load_cnt_o = wr_data_i[CNT_W-1:0];
        if (!wr_en_i) begin
            cmd_o = CMD_IDLE;
        end else if (wr_data_i[EN_BIT]) begin
            cmd_o = CMD_LOAD;
        end else begin
            cmd_o = CMD_CANCEL;
        end
    end

endmodule

// File: rtl/otgt_countdown.sv
module otgt_countdown
    import otgt_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  otgt_cmd_e        cmd_i,
    input  logic [CNT_W-1:0] load_cnt_i,
    input  logic             tick_i,
    output logic             expire_o,
    output logic             pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             pulse;
    } cd_state_t;

    localparam cd_state_t RESET_STATE = '{cnt: '0, run: 1'b0, pulse: 1'b0};

    cd_state_t state_d, state_q;
    logic      expire;

    always_comb begin
        state_d       = state_q;
        state_d.pulse = 1'b0;
        expire        = 1'b0;
        unique case (cmd_i)
            CMD_LOAD: begin
                state_d.cnt = load_cnt_i;
                state_d.run = 1'b1;
            end
            CMD_CANCEL: begin
                state_d.run = 1'b0;
            end
            default: begin
                if (state_q.run && tick_i) begin
                    // Counts of 0 and 1 both finish on this tick.
                    if (state_q.cnt <= CNT_W'(1)) begin
                        expire        = 1'b1;
                        state_d.cnt   = '0;
                        state_d.run   = 1'b0;
                        state_d.pulse = 1'b1;
                    end else begin
                        state_d.cnt = state_q.cnt - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign expire_o = expire;
    assign pulse_o  = state_q.pulse;

endmodule

// File: rtl/otgt_value_reg.sv
module otgt_value_reg
    import otgt_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              expire_i,
    output logic [DATA_W-1:0] value_o
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
    } vr_state_t;

    vr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.value = wr_data_i;
        end else if (expire_i) begin
            state_d.value = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign value_o = state_q.value;

endmodule

// File: rtl/otg_timeout_timer.sv
module otg_timeout_timer
    import otgt_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout
);

    otgt_cmd_e        cmd;
    logic [CNT_W-1:0] load_cnt;
    logic             expire;

    otgt_wr_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .cmd_o      (cmd),
        .load_cnt_o (load_cnt)
    );

    otgt_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .load_cnt_i (load_cnt),
        .tick_i     (tick),
        .expire_o   (expire),
        .pulse_o    (timeout)
    );

    otgt_value_reg #(.DATA_W(DATA_W)) u_val (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .expire_i   (expire),
        .value_o    (rd_data)
    );

endmodule

// File: rtl/otgt_checker.sv
module otgt_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic [DATA_W-1:0] rd_data,
    input logic              timeout
);

    p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    p_cancel_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[DATA_W-1]) |=> !timeout);

    p_zero_on_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> rd_data == '0);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    p_tick_needed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || wr_en) |=> !timeout);

    p_value_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (rd_data == $past(rd_data)) || timeout);

endmodule

bind otg_timeout_timer otgt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick),
    .rd_data (rd_data),
    .timeout (timeout)
);

// File: tb/otg_timeout_timer_tb.sv
module otg_timeout_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] rd_data;
    logic        timeout;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    otg_timeout_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tick    (tick),
        .rd_data (rd_data),
        .timeout (timeout)
    );

    localparam int NV = 6;
    localparam logic [31:0] VEC_DATA [NV] = '{
        32'h8000_0003, 32'h8000_0000, 32'hF800_0002,
        32'h8000_0001, 32'h8000_0005, 32'h8000_0040
    };
    localparam int VEC_TICKS [NV] = '{3, 1, 2, 1, 5, 64};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, sample 1 ns after the posedge.
    task automatic cyc(input logic w, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = w; wr_data = d; tick = t;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick = 1'b0;
    endtask

    // Apply n ticks; return the number of pulses seen.
    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, '0, 1'b1);
            if (timeout) pulses++;
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int p;
        repeat (3) @(posedge clk);
        #1;
        chk(rd_data == 0, "R1 reset rd_data", rd_data, 0);
        chk(timeout == 0, "R1 reset timeout", {31'd0, timeout}, 0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table: arm, then tick up to the expected expiry.
        for (int v = 0; v < NV; v++) begin
            cyc(1'b1, VEC_DATA[v], 1'b0);
            chk(rd_data == VEC_DATA[v], "R2 readback after arm", rd_data, VEC_DATA[v]);
            ticks(VEC_TICKS[v] - 1, p);
            chk(p == 0, "R3/R4/R5 no early pulse", p, 0);
            cyc(1'b0, '0, 1'b1);
            chk(timeout == 1'b1, "R3/R4/R5 pulse on last tick", {31'd0, timeout}, 1);
            chk(rd_data == 0, "R8 zero at expiry", rd_data, 0);
            cyc(1'b0, '0, 1'b0);
            chk(timeout == 1'b0, "R8 single cycle pulse", {31'd0, timeout}, 0);
        end

        // R9: ticks after expiry produce nothing.
        ticks(10, p);
        chk(p == 0, "R9 no pulse after expiry", p, 0);
        chk(rd_data == 0, "R9 value stays zero", rd_data, 0);

        // R2/R7: non-arming write holds its value and never fires.
        cyc(1'b1, 32'h7ABC_1234, 1'b0);
        ticks(12, p);
        chk(p == 0, "R7 disarmed write no pulse", p, 0);
        chk(rd_data == 32'h7ABC_1234, "R2 readback disarmed", rd_data, 32'h7ABC_1234);

        // R7: cancel mid-count.
        cyc(1'b1, 32'h8000_0004, 1'b0);
        ticks(2, p);
        cyc(1'b1, 32'h0000_0000, 1'b0);
        ticks(10, p);
        chk(p == 0, "R7 cancel mid-count", p, 0);
        chk(rd_data == 0, "R7 cancel readback", rd_data, 0);

        // R6: restart during countdown.
        cyc(1'b1, 32'h8000_0003, 1'b0);
        ticks(2, p);
        cyc(1'b1, 32'h8000_0003, 1'b0);
        ticks(2, p);
        chk(p == 0, "R6 restart no early pulse", p, 0);
        cyc(1'b0, '0, 1'b1);
        chk(timeout == 1'b1, "R6 restart pulse on 3rd tick", {31'd0, timeout}, 1);

        // R10: idle cycles do not count.
        cyc(1'b1, 32'h8000_0002, 1'b0);
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, '0, 1'b0);
            if (timeout) p++;
        end
        chk(timeout == 0, "R10 idle cycles no pulse", {31'd0, timeout}, 0);
        chk(rd_data == 32'h8000_0002, "R10 value held while idle", rd_data, 32'h8000_0002);
        ticks(1, p);
        chk(p == 0, "R10 one tick of two", p, 0);
        ticks(1, p);
        chk(p == 1, "R10 second tick fires", p, 1);

        // R10: tick concurrent with write is not counted.
        cyc(1'b1, 32'h8000_0002, 1'b1);
        ticks(1, p);
        chk(p == 0, "R10 write-cycle tick ignored", p, 0);
        ticks(1, p);
        chk(p == 1, "R10 fires after two real ticks", p, 1);

        // R1: reset mid-count clears everything.
        cyc(1'b1, 32'h8000_0002, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(rd_data == 0, "R1 reset mid-count", rd_data, 0);
        ticks(4, p);
        chk(p == 0, "R1 no pulse after reset", p, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule